// File: doc/BRIEF.md
# Multiply-Add Register File Datapath

This block evaluates F = a*b + c + d with a single arithmetic unit that can either add or multiply in one clock cycle. When start is seen while the block is idle, the four operands are copied from their input ports into the lowest four entries of an internal register file (8 entries of 16 bits by default). A sequencer then issues three operations in a fixed order: the product a*b, then that product plus c, then that sum plus d. Every partial result is written back to a spare register-file entry and read back from there by the next operation. The final sum goes to its own entry, and that entry drives the result port.

Each operation passes through three stages: operand read into two operand staging registers, execute into an ALU output register, and writeback. A mode input, taken only in the cycle start is accepted, picks the schedule. In sequential mode each operation finishes its writeback before the next one reads. In overlapped mode the next read shares the cycle of the previous writeback, because the register file forwards a write to a read of the same entry in that cycle. Each following operation needs the result just computed, so it stalls for one cycle while that result sits in the execute stage. The done output pulses for one cycle when F is valid.

Top module: `madd_datapath`

## Requirements
- R1: During and after reset, done is 0 and result is 0.
- R2: When start is 1 while the block is idle, op_a..op_d are captured at that clock edge. The run then ends with result equal to (a*b + c + d) truncated to DATA_W bits.
- R3: The multiply keeps only the low DATA_W bits of the product, and each addition wraps modulo 2^DATA_W.
- R4: With mode_pipe = 0 at the accepting edge, done is 1 in the cycle that follows the 9th clock edge after the accepting edge.
- R5: With mode_pipe = 1 at the accepting edge, done is 1 in the cycle that follows the 7th clock edge after the accepting edge.
- R6: done is 1 for exactly one cycle per accepted start, and never without one.
- R7: While a run is in progress, start pulses and changes on op_a..op_d affect neither the result nor the timing of that run.
- R8: mode_pipe is sampled only at the accepting edge. Changing it during a run does not change that run's latency.
- R9: While the block is idle, result holds the last computed F.
- R10: A start given in the same cycle that done is 1 is accepted, so runs can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; taken only when idle |
| mode_pipe | input | 1 | 1 = overlapped schedule, 0 = sequential schedule |
| op_a | input | DATA_W | Multiplicand a |
| op_b | input | DATA_W | Multiplier b |
| op_c | input | DATA_W | First addend c |
| op_d | input | DATA_W | Second addend d |
| result | output | DATA_W | Last computed F |
| done | output | 1 | One-cycle pulse when result holds a new F |

## Verification
On every cycle the checker compares result against a sum it builds from the operands captured at acceptance. It also checks that each done lands at the latency of the latched mode, that done never lasts two cycles, and that result does not move while the block is idle. Only the bench's scenarios can show that a run ignores start pulses, operand changes and mode flips made while it is busy. They also show that a start in the done cycle begins a second run, and that wrapped products and sums come out right for chosen operand values.

// File: rtl/madd_pkg.sv
package madd_pkg;
   typedef enum logic {ALU_ADD = 1'b0, ALU_MUL = 1'b1} alu_op_e;

   // register-file slot plan
   localparam int unsigned SLOT_A   = 0;
   localparam int unsigned SLOT_B   = 1;
   localparam int unsigned SLOT_C   = 2;
   localparam int unsigned SLOT_D   = 3;
   localparam int unsigned SLOT_T1  = 4;
   localparam int unsigned SLOT_T2  = 5;
   localparam int unsigned SLOT_F   = 6;
   localparam int unsigned N_INPUTS = 4;
   localparam int unsigned N_SLOTS  = 7;
endpackage

// File: rtl/madd_regfile.sv
module madd_regfile
   import madd_pkg::*;
#(
   parameter int W      = 16,
   parameter int DEPTH  = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_en,
   input  logic [N_INPUTS-1:0][W-1:0]  load_data,
   input  logic                        wb_en,
   input  logic [AW-1:0]               wb_addr,
   input  logic [W-1:0]                wb_data,
   input  logic [AW-1:0]               rd_addr_a,
   input  logic [AW-1:0]               rd_addr_b,
   output logic [W-1:0]                rd_data_a,
   output logic [W-1:0]                rd_data_b,
   output logic [W-1:0]                final_q
);
   logic [W-1:0] mem_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_q[i] <= '0;
         end else if (load_en && (i < N_INPUTS)) begin
            mem_q[i] <= load_data[i];
         end else if (wb_en && (wb_addr == AW'(i))) begin
            mem_q[i] <= wb_data;
         end
      end
   end

   // write-through: a read of the entry under writeback sees the new value
   always_comb begin
      rd_data_a = (wb_en && wb_addr == rd_addr_a) ? wb_data : mem_q[rd_addr_a];
      rd_data_b = (wb_en && wb_addr == rd_addr_b) ? wb_data : mem_q[rd_addr_b];
   end

   assign final_q = mem_q[SLOT_F];
endmodule

// File: rtl/madd_alu.sv
module madd_alu
   import madd_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e       op,
   input  logic [W-1:0]  lhs,
   input  logic [W-1:0]  rhs,
   output logic [W-1:0]  y
);
   always_comb begin
      unique case (op)
         ALU_MUL: y = lhs * rhs;
         default: y = lhs + rhs;
      endcase
   end
endmodule

// File: rtl/madd_seq.sv
module madd_seq
   import madd_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           mode_pipe,
   output logic           load_en,
   output logic           rd_go,
   output logic [AW-1:0]  rd_addr_a,
   output logic [AW-1:0]  rd_addr_b,
   output logic           ex_v,
   output alu_op_e        ex_op,
   output logic           wb_v,
   output logic [AW-1:0]  wb_addr,
   output logic           busy,
   output logic           done
);
   localparam int N_OPS = 3;
   localparam int IW    = $clog2(N_OPS + 1);

   logic [IW-1:0] idx_q;
   logic          pipe_q;
   logic [AW-1:0] ex_dst_q;
   logic          ex_last_q;
   logic          wb_last_q;
   alu_op_e       iss_op;
   logic [AW-1:0] iss_dst;

   // fixed schedule: a*b -> T1, T1+c -> T2, T2+d -> F
   always_comb begin
      unique case (idx_q)
         IW'(0): begin
            iss_op = ALU_MUL; rd_addr_a = AW'(SLOT_A);
            rd_addr_b = AW'(SLOT_B); iss_dst = AW'(SLOT_T1);
         end
         IW'(1): begin
            iss_op = ALU_ADD; rd_addr_a = AW'(SLOT_T1);
            rd_addr_b = AW'(SLOT_C); iss_dst = AW'(SLOT_T2);
         end
         default: begin
            iss_op = ALU_ADD; rd_addr_a = AW'(SLOT_T2);
            rd_addr_b = AW'(SLOT_D); iss_dst = AW'(SLOT_F);
         end
      endcase
   end

   assign load_en = start && !busy;
   // every op depends on its predecessor: wait while it is in execute;
   // the sequential schedule also waits out its writeback
   assign rd_go = busy && (idx_q != IW'(N_OPS)) && !ex_v && (pipe_q || !wb_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pipe_q    <= 1'b0;
         idx_q     <= '0;
         ex_v      <= 1'b0;
         ex_op     <= ALU_ADD;
         ex_dst_q  <= '0;
         ex_last_q <= 1'b0;
         wb_v      <= 1'b0;
         wb_addr   <= '0;
         wb_last_q <= 1'b0;
         done      <= 1'b0;
      end else begin
         ex_v      <= rd_go;
         wb_v      <= ex_v;
         wb_addr   <= ex_dst_q;
         wb_last_q <= ex_last_q;
         done      <= wb_v && wb_last_q;
         if (rd_go) begin
            idx_q     <= idx_q + IW'(1);
            ex_op     <= iss_op;
            ex_dst_q  <= iss_dst;
            ex_last_q <= (idx_q == IW'(N_OPS - 1));
         end
         if (load_en) begin
            busy   <= 1'b1;
            pipe_q <= mode_pipe;
            idx_q  <= '0;
         end else if (wb_v && wb_last_q) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/madd_datapath.sv
module madd_datapath
   import madd_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int RF_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_pipe,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] op_c,
   input  logic [DATA_W-1:0] op_d,
   output logic [DATA_W-1:0] result,
   output logic              done
);
   localparam int AW = $clog2(RF_DEPTH);

   if (RF_DEPTH < N_SLOTS) begin : g_bad_depth
      $error("RF_DEPTH must provide at least %0d slots", N_SLOTS);
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic                             load_en, rd_go, ex_v, wb_v, busy;
   logic [AW-1:0]                    rd_addr_a, rd_addr_b, wb_addr;
   alu_op_e                          ex_op;
   logic [DATA_W-1:0]                rd_data_a, rd_data_b, alu_y;
   logic [DATA_W-1:0]                opnd_q1, opnd_q2, alu_q;
   logic [N_INPUTS-1:0][DATA_W-1:0]  load_data;

   assign load_data = {op_d, op_c, op_b, op_a};

   madd_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_pipe(mode_pipe),
      .load_en(load_en), .rd_go(rd_go), .rd_addr_a(rd_addr_a),
      .rd_addr_b(rd_addr_b), .ex_v(ex_v), .ex_op(ex_op), .wb_v(wb_v),
      .wb_addr(wb_addr), .busy(busy), .done(done)
   );

   madd_regfile #(.W(DATA_W), .DEPTH(RF_DEPTH)) u_rf (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
      .wb_en(wb_v), .wb_addr(wb_addr), .wb_data(alu_q),
      .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .final_q(result)
   );

   madd_alu #(.W(DATA_W)) u_alu (
      .op(ex_op), .lhs(opnd_q1), .rhs(opnd_q2), .y(alu_y)
   );

   // staging registers: two operand latches and the ALU output latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opnd_q1 <= '0;
         opnd_q2 <= '0;
         alu_q   <= '0;
      end else begin
         if (rd_go) begin
            opnd_q1 <= rd_data_a;
            opnd_q2 <= rd_data_b;
         end
         if (ex_v) begin
            alu_q <= alu_y;
         end
      end
   end
endmodule

// File: rtl/madd_datapath_chk.sv
module madd_datapath_chk #(
   parameter int W = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          mode_pipe,
   input logic [W-1:0]  op_a,
   input logic [W-1:0]  op_b,
   input logic [W-1:0]  op_c,
   input logic [W-1:0]  op_d,
   input logic [W-1:0]  result,
   input logic          done,
   input logic          busy
);
   logic          accept, run_q, mode_q;
   logic [4:0]    cnt_q;
   logic [W-1:0]  want_q;

   assign accept = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= 1'b0;
         cnt_q  <= '0;
         want_q <= '0;
      end else if (accept) begin
         run_q  <= 1'b1;
         mode_q <= mode_pipe;
         cnt_q  <= '0;
         want_q <= op_a * op_b + op_c + op_d;
      end else begin
         if (done) run_q <= 1'b0;
         if (run_q && cnt_q != 5'd31) cnt_q <= cnt_q + 5'd1;
      end
   end

   p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_q && result == want_q));
   p_lat_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_q) |-> cnt_q == 5'd9);
   p_lat_pipe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q) |-> cnt_q == 5'd7);
   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(result));
endmodule

bind madd_datapath madd_datapath_chk #(.W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .mode_pipe(mode_pipe),
   .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
   .result(result), .done(done), .busy(busy)
);

// File: tb/madd_datapath_test.sv
`timescale 1ns/1ps
module madd_datapath_test;
   localparam int W = 16;

   typedef struct {
      logic [W-1:0] f;
      int           lat;
      int           s;
      string        tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          mode_pipe = 1'b0;
   logic [W-1:0]  op_a = '0, op_b = '0, op_c = '0, op_d = '0;
   logic [W-1:0]  result;
   logic          done;

   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   bit    done_prev = 0;
   item_t sb[$];
   item_t it;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   madd_datapath #(.DATA_W(W), .RF_DEPTH(8)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_pipe(mode_pipe),
      .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
      .result(result), .done(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model(input logic [W-1:0] a, b, c, d);
      logic [31:0] p;
      p = ({16'd0, a} * {16'd0, b}) & 32'h0000_FFFF;
      p = (p + {16'd0, c}) & 32'h0000_FFFF;
      p = (p + {16'd0, d}) & 32'h0000_FFFF;
      return p[W-1:0];
   endfunction

   // driver: called at a negedge; returns at the negedge where done is 1
   task automatic run(input logic [W-1:0] a, b, c, d, input logic m,
                      input int nz, input string tag);
      item_t e;
      op_a = a; op_b = b; op_c = c; op_d = d; mode_pipe = m; start = 1'b1;
      e.f = model(a, b, c, d); e.lat = m ? 7 : 9; e.s = cyc + 1; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
      if (nz == 1) begin
         for (int k = 0; k < 3; k++) begin
            op_a = ~op_a; op_c = op_c + 16'h0101; start = (k == 1);
            @(negedge clk);
         end
         start = 1'b0;
      end else if (nz == 2) begin
         mode_pipe = ~m;
      end
      while (!done) @(negedge clk);
   endtask

   // monitor: scoreboard compare on each done
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (done_prev) begin
               checks++; errors++;
               $display("FAIL R6 done high two cycles actual=1 expected=0");
            end
            if (sb.size() == 0) begin
               checks++; errors++;
               $display("FAIL R6 done without start actual=1 expected=0");
            end else begin
               it = sb.pop_front();
               chk({it.tag, " result"}, 32'(result), 32'(it.f));
               chk({it.tag, " latency"}, 32'(cyc - it.s), 32'(it.lat));
            end
         end
         done_prev = done;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      chk("R1 done in reset", 32'(done), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done after reset", 32'(done), 32'd0);
      chk("R1 result after reset", 32'(result), 32'd0);

      run(16'd3, 16'd4, 16'd5, 16'd6, 1'b0, 0, "R2 R4 sequential");
      repeat (4) @(negedge clk);
      chk("R9 result held idle", 32'(result), 32'd23);
      chk("R6 done low idle", 32'(done), 32'd0);

      run(16'd3, 16'd4, 16'd5, 16'd6, 1'b1, 0, "R2 R5 overlapped");
      repeat (2) @(negedge clk);
      run(16'hFFFF, 16'hFFFF, 16'd1, 16'd1, 1'b0, 0, "R3 product wrap");
      repeat (2) @(negedge clk);
      run(16'h1234, 16'h0010, 16'h00FF, 16'hFF00, 1'b1, 0, "R3 sum wrap");
      repeat (2) @(negedge clk);
      run(16'h0102, 16'h0304, 16'h0506, 16'h0708, 1'b0, 1, "R7 busy noise");
      repeat (2) @(negedge clk);
      run(16'h0021, 16'h0013, 16'h7000, 16'h9001, 1'b1, 2, "R8 mode flip pipe");
      repeat (2) @(negedge clk);
      run(16'h00A5, 16'h005A, 16'h0001, 16'h0002, 1'b0, 2, "R8 mode flip seq");
      // back to back: start issued in the done cycle of the previous run
      run(16'd7, 16'd9, 16'd11, 16'd13, 1'b1, 0, "R10 first");
      run(16'd100, 16'd200, 16'd300, 16'd400, 1'b0, 0, "R10 second");
      run(16'hABCD, 16'h0002, 16'h0000, 16'hFFFF, 1'b1, 0, "R10 third");

      repeat (12) @(negedge clk);
      chk("R6 every start produced one done", 32'(sb.size()), 32'd0);
      chk("R9 result held after last run", 32'(result),
          32'(model(16'hABCD, 16'h0002, 16'h0000, 16'hFFFF)));

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule